// File: doc/BRIEF.md
# Critical-Word-First Line Fill Buffer

This block gathers one cache line from a narrow memory data bus after a miss. The line is 32 bytes and the bus carries 8 bytes per beat, so a fill is four beats. The miss request names the line and the byte that missed. The block asks the bus for the chunk that holds that byte first, and hands that chunk straight to the core on an early-data port. The core can restart at once while the other three chunks are still arriving.

After the first chunk, the remaining chunks come in wrapped order. The chunk index for beat k is the critical index XOR k. Every beat is stored in the buffer slot named by its chunk index, whatever its place in the arrival order. When the last beat is in, the whole line goes to the cache array in one wide write. The buffer then frees itself for the next miss. While a fill is in progress the block reports busy and ignores any new miss request.

Top module: `line_fill_cwf`

## Requirements
- R1: After reset, `miss_busy`, `bus_req_valid`, `early_valid` and `line_we` are all 0.
- R2: A miss presented while idle is accepted at the next clock edge. In the cycle that follows, `bus_req_valid` is high for exactly one cycle and `bus_req_addr` equals {line, chunk, three zero bits}, where chunk is `miss_offset[4:3]`. For a miss at byte address 0x95, this address is 0x90.
- R3: Beat k of a fill (k = 0..3, counting only cycles with `beat_valid` high) carries chunk (critical chunk XOR k). It is stored so that `line_data[64*c +: 64]` holds chunk c, so chunk 0 sits in the least significant bits.
- R4: In the cycle after the first beat is taken, `early_valid` is high for exactly one cycle. In that cycle `early_data` equals the first beat and `early_chunk` equals the critical chunk index.
- R5: In the cycle after the fourth beat is taken, `line_we` is high for exactly one cycle. In that cycle `line_addr` equals the accepted miss line and `line_data` holds the complete line.
- R6: `miss_busy` is high from the cycle after acceptance through the `line_we` cycle, and low in the cycle after it. A miss request presented while busy is ignored: it raises no bus request and does not change the line that is written.
- R7: Beats presented while no fill is in progress are ignored. They raise neither `early_valid` nor `line_we`, and they do not shift the beat count of a later fill.
- R8: Cycles with `beat_valid` low inside a fill take no beat. A fill with idle gaps between beats produces the same early chunk and the same line as a fill without gaps.
- R9: A miss presented in the first cycle after the line write is accepted, so fills can follow one another back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Miss request strobe |
| miss_line | input | 27 | Line address of the miss |
| miss_offset | input | 5 | Byte offset of the missed byte within the line |
| miss_busy | output | 1 | Fill in progress; miss requests are refused |
| bus_req_valid | output | 1 | One-cycle request to start the wrapped bus fetch |
| bus_req_addr | output | 32 | Byte address of the critical chunk |
| beat_valid | input | 1 | Bus beat strobe |
| beat_data | input | 64 | Bus beat data |
| early_valid | output | 1 | One-cycle strobe for the critical chunk to the core |
| early_data | output | 64 | Critical chunk data |
| early_chunk | output | 2 | Chunk index of the critical chunk |
| line_we | output | 1 | One-cycle write strobe to the cache array |
| line_addr | output | 27 | Line address for the cache write |
| line_data | output | 256 | Complete line, chunk 0 in the low bits |

## Verification
Two situations are hard to reach from the ports. The first is a miss request that arrives during a fill. The second is a beat strobe while no fill is open. Both have to leave every later output unchanged. The stimulus drives bus strobes straight after reset, before any miss, and then runs a normal fill whose line must come out intact. It also places a second miss with a different address inside a beat gap, and checks that no bus request follows and that the written line address still belongs to the first miss. The fills cover critical chunks 0 to 3, so that all four XOR orders, including the non-rotational 1, 0, 3, 2, are exercised. One pair of fills is issued back to back.

// File: rtl/lfb_pkg.sv
package lfb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WRITE = 2'd2
  } fill_state_e;

  // Chunk index that arrives on a given beat of a wrapped fill.
  function automatic int unsigned wrap_chunk(input int unsigned crit,
                                             input int unsigned beat);
    return crit ^ beat;
  endfunction

  // Chunk index that holds a byte offset within the line.
  function automatic int unsigned chunk_of(input int unsigned offset,
                                           input int unsigned lane_bits);
    return offset >> lane_bits;
  endfunction

endpackage

// File: rtl/lfb_seq.sv
module lfb_seq #(
  parameter int BEATS   = 4,
  parameter int LINE_AW = 27,
  localparam int CHUNK_W = $clog2(BEATS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               miss_valid,
  input  logic [LINE_AW-1:0] miss_line,
  input  logic [CHUNK_W-1:0] miss_chunk,
  input  logic               beat_valid,
  output logic               busy,
  output logic               accept,
  output logic               bus_req_valid,
  output logic               beat_take,
  output logic               first_beat,
  output logic [CHUNK_W-1:0] beat_slot,
  output logic               line_we,
  output logic [LINE_AW-1:0] cur_line,
  output logic [CHUNK_W-1:0] cur_crit
);
  import lfb_pkg::*;

  localparam logic [CHUNK_W-1:0] LAST_BEAT = CHUNK_W'(BEATS - 1);

  fill_state_e        state_q;
  logic [CHUNK_W-1:0] cnt_q;
  logic [CHUNK_W-1:0] crit_q;
  logic [LINE_AW-1:0] line_q;
  logic               req_q;

  assign accept     = miss_valid && (state_q == ST_IDLE);
  assign beat_take  = beat_valid && (state_q == ST_FILL);
  assign first_beat = beat_take && (cnt_q == '0);
  assign beat_slot  = CHUNK_W'(wrap_chunk(32'(crit_q), 32'(cnt_q)));
  assign line_we    = (state_q == ST_WRITE);
  assign busy       = (state_q != ST_IDLE);
  assign bus_req_valid = req_q;
  assign cur_line   = line_q;
  assign cur_crit   = crit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      crit_q  <= '0;
      line_q  <= '0;
      req_q   <= 1'b0;
    end else begin
      req_q <= accept;
      case (state_q)
        ST_IDLE: begin
          if (miss_valid) begin
            state_q <= ST_FILL;
            cnt_q   <= '0;
            crit_q  <= miss_chunk;
            line_q  <= miss_line;
          end
        end
        ST_FILL: begin
          if (beat_valid) begin
            cnt_q <= cnt_q + CHUNK_W'(1);
            if (cnt_q == LAST_BEAT) state_q <= ST_WRITE;
          end
        end
        ST_WRITE: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |=> !bus_req_valid);

  // R5
  line_we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_we |=> !line_we);

  // R6
  release_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_we |=> !busy);

endmodule

// File: rtl/lfb_store.sv
module lfb_store #(
  parameter int BEATS = 4,
  parameter int BUS_W = 64,
  localparam int CHUNK_W = $clog2(BEATS),
  localparam int LINE_W  = BEATS * BUS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_start,
  input  logic               wr_en,
  input  logic [CHUNK_W-1:0] wr_slot,
  input  logic [BUS_W-1:0]   wr_data,
  input  logic               commit,
  output logic [LINE_W-1:0]  line_data
);

  logic [BEATS-1:0] slot_we;
  logic [BEATS-1:0] written_q;

  for (genvar s = 0; s < BEATS; s++) begin : g_slot
    logic [BUS_W-1:0] slot_q;
    assign slot_we[s] = wr_en && (wr_slot == CHUNK_W'(s));
    always_ff @(posedge clk) begin
      if (slot_we[s]) slot_q <= wr_data;
    end
    assign line_data[s*BUS_W +: BUS_W] = slot_q;
  end

  // Tracks which slots the current fill has filled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          written_q <= '0;
    else if (fill_start) written_q <= '0;
    else                 written_q <= written_q | slot_we;
  end

  // R3
  no_rewrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((slot_we & written_q) == '0));

  // R5
  full_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (&written_q));

endmodule

// File: rtl/lfb_early.sv
module lfb_early #(
  parameter int BUS_W   = 64,
  parameter int CHUNK_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               first_beat,
  input  logic [BUS_W-1:0]   beat_data,
  input  logic [CHUNK_W-1:0] beat_slot,
  output logic               early_valid,
  output logic [BUS_W-1:0]   early_data,
  output logic [CHUNK_W-1:0] early_chunk
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      early_valid <= 1'b0;
      early_data  <= '0;
      early_chunk <= '0;
    end else begin
      early_valid <= first_beat;
      if (first_beat) begin
        early_data  <= beat_data;
        early_chunk <= beat_slot;
      end
    end
  end

  // R4
  early_one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    early_valid |=> !early_valid);

endmodule

// File: rtl/line_fill_cwf.sv
module line_fill_cwf #(
  parameter int LINE_BYTES = 32,
  parameter int BUS_BYTES  = 8,
  parameter int ADDR_W     = 32,
  localparam int BEATS   = LINE_BYTES / BUS_BYTES,
  localparam int BUS_W   = 8 * BUS_BYTES,
  localparam int LINE_W  = 8 * LINE_BYTES,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int LANE_W  = $clog2(BUS_BYTES),
  localparam int CHUNK_W = OFF_W - LANE_W,
  localparam int LINE_AW = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               miss_valid,
  input  logic [LINE_AW-1:0] miss_line,
  input  logic [OFF_W-1:0]   miss_offset,
  output logic               miss_busy,
  output logic               bus_req_valid,
  output logic [ADDR_W-1:0]  bus_req_addr,
  input  logic               beat_valid,
  input  logic [BUS_W-1:0]   beat_data,
  output logic               early_valid,
  output logic [BUS_W-1:0]   early_data,
  output logic [CHUNK_W-1:0] early_chunk,
  output logic               line_we,
  output logic [LINE_AW-1:0] line_addr,
  output logic [LINE_W-1:0]  line_data
);
  import lfb_pkg::*;

  logic [CHUNK_W-1:0] miss_chunk;
  logic               accept;
  logic               beat_take;
  logic               first_beat;
  logic [CHUNK_W-1:0] beat_slot;
  logic [CHUNK_W-1:0] cur_crit;

  assign miss_chunk = CHUNK_W'(chunk_of(32'(miss_offset), LANE_W));

  lfb_seq #(.BEATS(BEATS), .LINE_AW(LINE_AW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .miss_valid   (miss_valid),
    .miss_line    (miss_line),
    .miss_chunk   (miss_chunk),
    .beat_valid   (beat_valid),
    .busy         (miss_busy),
    .accept       (accept),
    .bus_req_valid(bus_req_valid),
    .beat_take    (beat_take),
    .first_beat   (first_beat),
    .beat_slot    (beat_slot),
    .line_we      (line_we),
    .cur_line     (line_addr),
    .cur_crit     (cur_crit)
  );

  assign bus_req_addr = {line_addr, cur_crit, LANE_W'(0)};

  lfb_store #(.BEATS(BEATS), .BUS_W(BUS_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_start(accept),
    .wr_en     (beat_take),
    .wr_slot   (beat_slot),
    .wr_data   (beat_data),
    .commit    (line_we),
    .line_data (line_data)
  );

  lfb_early #(.BUS_W(BUS_W), .CHUNK_W(CHUNK_W)) u_early (
    .clk        (clk),
    .rst_n      (rst_n),
    .first_beat (first_beat),
    .beat_data  (beat_data),
    .beat_slot  (beat_slot),
    .early_valid(early_valid),
    .early_data (early_data),
    .early_chunk(early_chunk)
  );

  // R4
  early_in_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    early_valid |-> miss_busy);

  // R6
  write_in_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_we |-> (miss_busy && !early_valid));

endmodule

// File: tb/line_fill_cwf_tb.sv
`timescale 1ns/1ps
module line_fill_cwf_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         miss_valid = 1'b0;
  logic [26:0]  miss_line = '0;
  logic [4:0]   miss_offset = '0;
  logic         miss_busy;
  logic         bus_req_valid;
  logic [31:0]  bus_req_addr;
  logic         beat_valid = 1'b0;
  logic [63:0]  beat_data = '0;
  logic         early_valid;
  logic [63:0]  early_data;
  logic [1:0]   early_chunk;
  logic         line_we;
  logic [26:0]  line_addr;
  logic [255:0] line_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0]  exp_early_q[$];
  logic [1:0]   exp_echk_q[$];
  logic [255:0] exp_line_q[$];
  logic [26:0]  exp_addr_q[$];

  always #10 clk = ~clk;

  line_fill_cwf u_dut (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_line(miss_line), .miss_offset(miss_offset),
    .miss_busy(miss_busy),
    .bus_req_valid(bus_req_valid), .bus_req_addr(bus_req_addr),
    .beat_valid(beat_valid), .beat_data(beat_data),
    .early_valid(early_valid), .early_data(early_data), .early_chunk(early_chunk),
    .line_we(line_we), .line_addr(line_addr), .line_data(line_data)
  );

  function automatic logic [63:0] pat(input logic [26:0] ln, input logic [1:0] c);
    return 64'hF00D_0000_0000_0000 ^ (64'(ln) << 16) ^ (64'(c) << 4) ^ 64'(c);
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected items as results appear.
  always @(negedge clk) begin
    if (rst_n && early_valid) begin
      if (exp_early_q.size() == 0) begin
        check(1'b0, "R4/R7 unexpected early_valid", 256'(early_data), 0);
      end else begin
        logic [63:0] ed;
        logic [1:0]  ec;
        ed = exp_early_q.pop_front();
        ec = exp_echk_q.pop_front();
        check(early_data == ed, "R4 early_data", 256'(early_data), 256'(ed));
        check(early_chunk == ec, "R4 early_chunk", 256'(early_chunk), 256'(ec));
      end
    end
    if (rst_n && line_we) begin
      if (exp_line_q.size() == 0) begin
        check(1'b0, "R5/R7 unexpected line_we", line_data, 0);
      end else begin
        logic [255:0] ld;
        logic [26:0]  la;
        ld = exp_line_q.pop_front();
        la = exp_addr_q.pop_front();
        check(line_data == ld, "R3/R5 line_data", line_data, ld);
        check(line_addr == la, "R5/R6 line_addr", 256'(line_addr), 256'(la));
      end
    end
  end

  // Driver: runs one fill; starts right after a falling edge.
  task automatic run_fill(input logic [26:0] ln, input logic [4:0] off,
                          input int gap, input bit intrude);
    logic [1:0]   crit;
    logic [255:0] full;
    crit = off[4:3];
    for (int c = 0; c < 4; c++) full[c*64 +: 64] = pat(ln, 2'(c));
    exp_early_q.push_back(pat(ln, crit));
    exp_echk_q.push_back(crit);
    exp_line_q.push_back(full);
    exp_addr_q.push_back(ln);

    miss_valid = 1'b1; miss_line = ln; miss_offset = off;
    @(negedge clk);
    miss_valid = 1'b0;
    check(bus_req_valid == 1'b1, "R2 bus_req_valid", 256'(bus_req_valid), 1);
    check(bus_req_addr == {ln, crit, 3'b000}, "R2 bus_req_addr",
          256'(bus_req_addr), 256'({ln, crit, 3'b000}));
    check(miss_busy == 1'b1, "R6 busy after accept", 256'(miss_busy), 1);

    for (int k = 0; k < 4; k++) begin
      for (int g = 0; g < gap; g++) begin
        beat_valid = 1'b0;
        if (intrude && k == 1 && g == 0) begin
          miss_valid = 1'b1; miss_line = ~ln; miss_offset = 5'h00;
        end
        @(negedge clk);
        miss_valid = 1'b0;
        // R8: gap cycles take no beat; R6: no new request while busy
        check(bus_req_valid == 1'b0, "R6 no request while busy",
              256'(bus_req_valid), 0);
      end
      beat_valid = 1'b1;
      beat_data  = pat(ln, crit ^ 2'(k));   // R3 wrapped order
      @(negedge clk);
      beat_valid = 1'b0;
    end
    check(miss_busy == 1'b1, "R6 busy during write", 256'(miss_busy), 1);
    @(negedge clk);
    check(miss_busy == 1'b0, "R6 busy released", 256'(miss_busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check({miss_busy, bus_req_valid, early_valid, line_we} == 4'b0,
          "R1 reset outputs", 256'({miss_busy, bus_req_valid, early_valid, line_we}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: stray beats while idle
    for (int i = 0; i < 3; i++) begin
      beat_valid = 1'b1; beat_data = 64'hDEAD_BEEF_0000_0000 + 64'(i);
      @(negedge clk);
      check(!early_valid && !line_we && !miss_busy, "R7 idle beat ignored",
            256'({early_valid, line_we, miss_busy}), 0);
    end
    beat_valid = 1'b0;
    @(negedge clk);
    check(!early_valid && !line_we, "R7 idle beat ignored",
          256'({early_valid, line_we}), 0);

    run_fill(27'h4, 5'h15, 0, 1'b0);          // 0x95: chunk 2, order 2,3,0,1
    run_fill(27'h1234, 5'h00, 0, 1'b0);       // R9 back to back, chunk 0
    run_fill(27'h7ABCDE, 5'h0F, 2, 1'b1);     // R8 gaps, R6 intruding miss, chunk 1
    run_fill(27'h155, 5'h1F, 1, 1'b0);        // chunk 3, order 3,2,1,0
    repeat (2) @(negedge clk);
    run_fill(27'h3FFFFFF, 5'h08, 3, 1'b1);    // chunk 1 again with gaps

    repeat (4) @(negedge clk);
    check(exp_early_q.size() == 0 && exp_line_q.size() == 0,
          "R4/R5 all expected results seen",
          256'(exp_early_q.size() + exp_line_q.size()), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule